// File: doc/BRIEF.md
# Dual-clock 32-bit real-time counter

This block keeps a 32-bit count that steps on a slow counter clock. Software reaches it through a byte-wide register port that runs on a faster system clock. The count, the period and a compare value are each seen as four byte registers. When the count equals the period, the count returns to zero on the following counter cycle and an overflow event is raised. When the count equals the compare value, a compare event is raised. Both events latch sticky flags in the system domain. Both also leave as one-cycle wake-up pulses in the counter domain.

Software loads the count by writing its bytes. Writing the top byte hands the whole 32-bit value to the counter domain, and a busy flag stays up until that domain has taken it. Reading the count works on request: writing the sync bit arms a fixed eight-cycle timer. When the timer expires, a copy of the count that was carried safely across the boundary becomes readable. The register port takes one access per cycle and never stalls. Reads are combinational on the address, and writes take effect at the next system clock edge. There is no valid/ready handshake, because the port has no back-pressure.

Register map (byte addresses): 0 control (bit 0 enable), 1 status (bit 0 busy, read only), 2 sync (bit 0: write 1 to request a snapshot, reads 1 while the request is pending), 3 flags (bit 0 overflow, bit 1 compare), 4–7 count, 8–11 period, 12–15 compare. Within each 32-bit value, the least significant byte is at the lowest address.

Top module: `rtc32_dual`

## Requirements
- R1: After reset every register reads zero and both flag outputs are low. Count, period and compare bytes map least significant byte first, at addresses 4, 8 and 12.
- R2: While busy (status bit 0) is set, writes to any of the count bytes 4–7 are dropped. This covers the staged lower bytes as well.
- R3: A write of 1 to sync bit 0 makes the count copy readable at addresses 4–7 exactly 8 system cycles after the write edge. Reads before then return the previous copy.
- R4: While enabled, a count equal to the period becomes zero on the next counter cycle, so the count repeats every period+1 counter cycles.
- R5: The overflow wake pulse and flag are raised on the counter step that takes the count to zero after a period match, not in the cycle in which the match is first seen.
- R6: While enabled, a count equal to the compare value raises the compare wake pulse one counter cycle later and sets flag bit 1.
- R7: Writes to period bytes 8–11 and compare bytes 12–15 are dropped unless control bit 0 is clear, the counter domain has seen it clear, and busy is clear.
- R8: Writing count byte 7 sets busy. The staged 32-bit value is then loaded into the count, and busy clears after the counter domain acknowledges the load.
- R9: For the two counter cycles after a count load, neither the overflow nor the compare condition can raise a flag or a wake pulse. The period wrap itself still takes place.
- R10: The count advances only while the enable bit, as seen in the counter domain, is set. It holds its value otherwise.
- R11: Writing 1 to a bit of the flags register clears that flag (bit 0 overflow, bit 1 compare). Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock for the register port |
| sys_rst_n | input | 1 | Asynchronous active-low reset, system domain |
| cnt_clk | input | 1 | Slow counter clock |
| cnt_rst_n | input | 1 | Asynchronous active-low reset, counter domain |
| bus_addr | input | 4 | Byte register address |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| ovf_flag | output | 1 | Sticky overflow flag (system domain) |
| cmp_flag | output | 1 | Sticky compare flag (system domain) |
| ovf_wake | output | 1 | One-cycle overflow wake pulse (counter domain) |
| cmp_wake | output | 1 | One-cycle compare wake pulse (counter domain) |

## Verification
The wrap is tested with a short period and a compare value of zero. The spacing of the overflow pulses shows whether the wrap adds a cycle. Because a compare pulse on zero must follow each overflow pulse by one cycle, this run also shows whether overflow marks the step to zero or the match itself. Count loads are driven in two patterns. One is a second burst of byte writes while busy, followed by a lone top-byte write, which shows whether dropped writes leaked into the staging bytes. The other is a load of exactly the period value while running, set against a load just below it, which separates blanking from plain counting. Snapshot reads are sampled one cycle before and at the promised cycle, and period writes are tried while running, while stopped and while busy.

// File: rtl/rtc32_pkg.sv
package rtc32_pkg;
  // control-space byte addresses; multi-byte values follow at CNT_BASE
  localparam int ADR_CTRL   = 0;
  localparam int ADR_STATUS = 1;
  localparam int ADR_SYNC   = 2;
  localparam int ADR_FLAGS  = 3;
  localparam int CNT_BASE   = 4;
  // flag bit positions
  localparam int FLG_OVF = 0;
  localparam int FLG_CMP = 1;
endpackage

// File: rtl/rtc32_sync.sv
module rtc32_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '0;
    else        ff <= {ff[STAGES-2:0], d};
  end
  assign q = ff[STAGES-1];
endmodule

// File: rtl/rtc32_core.sv
module rtc32_core #(
  parameter int CW        = 32,
  parameter int BLANK_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_lvl,
  input  logic          ld_tog,
  input  logic [CW-1:0] ld_val,
  input  logic [CW-1:0] per,
  input  logic [CW-1:0] cmp,
  input  logic          pub_ack_tog,
  output logic          en_seen,
  output logic          ld_ack_tog,
  output logic          pub_tog,
  output logic [CW-1:0] pub_val,
  output logic          ovf_tog,
  output logic          cmp_tog,
  output logic          ovf_wake,
  output logic          cmp_wake
);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic en_s, ld_s, pa_s;
  logic ld_seen;
  logic [CW-1:0] cnt;
  logic [BW-1:0] blank;

  rtc32_sync u_en (.clk(clk), .rst_n(rst_n), .d(en_lvl),      .q(en_s));
  rtc32_sync u_ld (.clk(clk), .rst_n(rst_n), .d(ld_tog),      .q(ld_s));
  rtc32_sync u_pa (.clk(clk), .rst_n(rst_n), .d(pub_ack_tog), .q(pa_s));

  logic load, quiet, per_hit, cmp_eq;
  assign load    = ld_s ^ ld_seen;
  assign quiet   = (blank == '0);
  assign per_hit = (cnt == per);
  assign cmp_eq  = (cnt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_seen  <= 1'b0;
      cnt      <= '0;
      blank    <= '0;
      ovf_tog  <= 1'b0;
      cmp_tog  <= 1'b0;
      ovf_wake <= 1'b0;
      cmp_wake <= 1'b0;
      pub_tog  <= 1'b0;
      pub_val  <= '0;
    end else begin
      ovf_wake <= 1'b0;
      cmp_wake <= 1'b0;
      if (load) begin
        ld_seen <= ld_s;
        cnt     <= ld_val;
        blank   <= BW'(BLANK_CYC);
      end else begin
        if (!quiet) blank <= blank - 1'b1;
        if (en_s) begin
          cnt <= per_hit ? '0 : cnt + 1'b1;
          if (per_hit && quiet) begin
            ovf_wake <= 1'b1;
            ovf_tog  <= ~ovf_tog;
          end
          if (cmp_eq && quiet) begin
            cmp_wake <= 1'b1;
            cmp_tog  <= ~cmp_tog;
          end
        end
      end
      // publish a fresh copy once the previous one has been taken
      if (pa_s == pub_tog) begin
        pub_val <= cnt;
        pub_tog <= ~pub_tog;
      end
    end
  end

  assign en_seen    = en_s;
  assign ld_ack_tog = ld_seen;

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && !load && per_hit) |=> (cnt == '0));
  // R5
  ovf_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_wake |-> (cnt == '0));
  // R9
  blank_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load, 2) || $past(load, 3)) |-> (!ovf_wake && !cmp_wake));
  // R10
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s && !load) |=> $stable(cnt));
endmodule

// File: rtl/rtc32_regs.sv
module rtc32_regs
  import rtc32_pkg::*;
#(
  parameter int CW         = 32,
  parameter int NB         = 4,
  parameter int ADDR_W     = 4,
  parameter int SNAP_DELAY = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              ovf_flag,
  output logic              cmp_flag,
  output logic              en_lvl,
  output logic              ld_tog,
  output logic [CW-1:0]     ld_val,
  output logic [CW-1:0]     per,
  output logic [CW-1:0]     cmp,
  output logic              pub_ack_tog,
  input  logic              ld_ack_tog,
  input  logic              en_seen,
  input  logic              pub_tog,
  input  logic [CW-1:0]     pub_val,
  input  logic              ovf_tog,
  input  logic              cmp_tog
);
  localparam int PER_BASE = CNT_BASE + NB;
  localparam int CMP_BASE = CNT_BASE + 2 * NB;
  localparam int TW       = $clog2(SNAP_DELAY + 1);

  logic ack_s, enb_s, pt_s, ot_s, ct_s;
  rtc32_sync u_ack (.clk(clk), .rst_n(rst_n), .d(ld_ack_tog), .q(ack_s));
  rtc32_sync u_enb (.clk(clk), .rst_n(rst_n), .d(en_seen),    .q(enb_s));
  rtc32_sync u_pt  (.clk(clk), .rst_n(rst_n), .d(pub_tog),    .q(pt_s));
  rtc32_sync u_ot  (.clk(clk), .rst_n(rst_n), .d(ovf_tog),    .q(ot_s));
  rtc32_sync u_ct  (.clk(clk), .rst_n(rst_n), .d(cmp_tog),    .q(ct_s));

  int a_i;
  assign a_i = int'(bus_addr);

  logic busy, cfg_ok, cnt_wr, top_wr, snap_req;
  logic pt_seen, ot_seen, ct_seen;
  logic [CW-1:0] stage, next_stage, mirror, snap;
  logic [TW-1:0] snap_tmr;

  assign busy     = ld_tog ^ ack_s;
  assign cfg_ok   = !en_lvl && !enb_s && !busy;
  assign cnt_wr   = bus_wr && !busy && (a_i >= CNT_BASE) && (a_i < PER_BASE);
  assign top_wr   = cnt_wr && (a_i == PER_BASE - 1);
  assign snap_req = bus_wr && (a_i == ADR_SYNC) && bus_wdata[0] && (snap_tmr == '0);

  always_comb begin
    next_stage = stage;
    for (int b = 0; b < NB; b++)
      if (a_i == CNT_BASE + b) next_stage[8*b +: 8] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_lvl   <= 1'b0;
      stage    <= '0;
      ld_val   <= '0;
      ld_tog   <= 1'b0;
      per      <= '0;
      cmp      <= '0;
      pt_seen  <= 1'b0;
      ot_seen  <= 1'b0;
      ct_seen  <= 1'b0;
      mirror   <= '0;
      snap     <= '0;
      snap_tmr <= '0;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (bus_wr && a_i == ADR_CTRL) en_lvl <= bus_wdata[0];
      if (cnt_wr) stage <= next_stage;
      if (top_wr) begin
        ld_val <= next_stage;
        ld_tog <= ~ld_tog;
      end
      for (int b = 0; b < NB; b++) begin
        if (bus_wr && cfg_ok && a_i == PER_BASE + b) per[8*b +: 8] <= bus_wdata;
        if (bus_wr && cfg_ok && a_i == CMP_BASE + b) cmp[8*b +: 8] <= bus_wdata;
      end
      if (pt_s ^ pt_seen) begin
        pt_seen <= pt_s;
        mirror  <= pub_val;
      end
      if (snap_req) snap_tmr <= TW'(SNAP_DELAY);
      else if (snap_tmr != '0) begin
        snap_tmr <= snap_tmr - 1'b1;
        if (snap_tmr == TW'(1)) snap <= mirror;
      end
      ot_seen <= ot_s;
      ct_seen <= ct_s;
      if (ot_s ^ ot_seen) ovf_flag <= 1'b1;
      else if (bus_wr && a_i == ADR_FLAGS && bus_wdata[FLG_OVF]) ovf_flag <= 1'b0;
      if (ct_s ^ ct_seen) cmp_flag <= 1'b1;
      else if (bus_wr && a_i == ADR_FLAGS && bus_wdata[FLG_CMP]) cmp_flag <= 1'b0;
    end
  end

  assign pub_ack_tog = pt_seen;

  always_comb begin
    bus_rdata = '0;
    if (a_i == ADR_CTRL)   bus_rdata[0] = en_lvl;
    if (a_i == ADR_STATUS) bus_rdata[0] = busy;
    if (a_i == ADR_SYNC)   bus_rdata[0] = (snap_tmr != '0);
    if (a_i == ADR_FLAGS) begin
      bus_rdata[FLG_OVF] = ovf_flag;
      bus_rdata[FLG_CMP] = cmp_flag;
    end
    for (int b = 0; b < NB; b++) begin
      if (a_i == CNT_BASE + b) bus_rdata = snap[8*b +: 8];
      if (a_i == PER_BASE + b) bus_rdata = per[8*b +: 8];
      if (a_i == CMP_BASE + b) bus_rdata = cmp[8*b +: 8];
    end
  end

  // R2
  cnt_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && busy && a_i >= CNT_BASE && a_i < PER_BASE)
      |=> ($stable(stage) && $stable(ld_val) && $stable(ld_tog)));
  // R7
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (en_lvl || enb_s || busy) && a_i >= PER_BASE)
      |=> ($stable(per) && $stable(cmp)));
  // R3
  snap_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snap) |-> ($past(snap_tmr) == TW'(1)));
  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_wr |=> busy);
endmodule

// File: rtl/rtc32_dual.sv
module rtc32_dual #(
  parameter int CW         = 32,
  parameter int SNAP_DELAY = 8,
  parameter int BLANK_CYC  = 2
) (
  input  logic       sys_clk,
  input  logic       sys_rst_n,
  input  logic       cnt_clk,
  input  logic       cnt_rst_n,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       ovf_flag,
  output logic       cmp_flag,
  output logic       ovf_wake,
  output logic       cmp_wake
);
  localparam int NB     = CW / 8;
  localparam int ADDR_W = $clog2(4 + 3 * NB);

  logic          en_lvl, ld_tog, pub_ack_tog;
  logic          en_seen, ld_ack_tog, pub_tog, ovf_tog, cmp_tog;
  logic [CW-1:0] ld_val, per, cmp, pub_val;

  rtc32_regs #(.CW(CW), .NB(NB), .ADDR_W(ADDR_W), .SNAP_DELAY(SNAP_DELAY)) u_regs (
    .clk(sys_clk), .rst_n(sys_rst_n),
    .bus_addr(bus_addr[ADDR_W-1:0]), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
    .en_lvl(en_lvl), .ld_tog(ld_tog), .ld_val(ld_val), .per(per), .cmp(cmp),
    .pub_ack_tog(pub_ack_tog), .ld_ack_tog(ld_ack_tog), .en_seen(en_seen),
    .pub_tog(pub_tog), .pub_val(pub_val), .ovf_tog(ovf_tog), .cmp_tog(cmp_tog)
  );

  rtc32_core #(.CW(CW), .BLANK_CYC(BLANK_CYC)) u_core (
    .clk(cnt_clk), .rst_n(cnt_rst_n),
    .en_lvl(en_lvl), .ld_tog(ld_tog), .ld_val(ld_val), .per(per), .cmp(cmp),
    .pub_ack_tog(pub_ack_tog), .en_seen(en_seen), .ld_ack_tog(ld_ack_tog),
    .pub_tog(pub_tog), .pub_val(pub_val), .ovf_tog(ovf_tog), .cmp_tog(cmp_tog),
    .ovf_wake(ovf_wake), .cmp_wake(cmp_wake)
  );
endmodule

// File: tb/tb_rtc32_dual.sv
module tb_rtc32_dual;
  localparam int A_CTRL = 0, A_STAT = 1, A_SYNC = 2, A_FLG = 3;
  localparam int A_CNT = 4, A_PER = 8, A_CMP = 12;

  logic sys_clk = 1'b0, cnt_clk = 1'b0;
  logic sys_rst_n = 1'b0, cnt_rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic ovf_flag, cmp_flag, ovf_wake, cmp_wake;

  int checks = 0, errors = 0;
  int cyc = 0, ovf_n = 0, cmp_n = 0, ovf_last = 0, ovf_gap = 0, pair_ok = 0;
  logic prev_ovf = 1'b0;

  always #10 sys_clk = ~sys_clk;
  always #35 cnt_clk = ~cnt_clk;

  rtc32_dual dut (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .ovf_wake(ovf_wake), .cmp_wake(cmp_wake)
  );

  // wake pulse monitor, sampled mid counter cycle
  always @(negedge cnt_clk) begin
    cyc = cyc + 1;
    if (ovf_wake) begin
      ovf_n = ovf_n + 1;
      if (ovf_last != 0) ovf_gap = cyc - ovf_last;
      ovf_last = cyc;
    end
    if (cmp_wake) begin
      cmp_n = cmp_n + 1;
      if (prev_ovf) pair_ok = pair_ok + 1;
    end
    prev_ovf = ovf_wake;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge sys_clk);
    bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge sys_clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    bus_addr = 4'(a);
    #1 d = bus_rdata;
  endtask

  task automatic wr32(input int base, input logic [31:0] v);
    for (int b = 0; b < 4; b++) wr(base + b, v[8*b +: 8]);
  endtask

  task automatic rd32(input int base, output logic [31:0] v);
    logic [7:0] t;
    for (int b = 0; b < 4; b++) begin rd(base + b, t); v[8*b +: 8] = t; end
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 200; i++) begin
      @(negedge sys_clk); rd(A_STAT, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge sys_clk);
    @(negedge sys_clk);
  endtask

  task automatic snap(output logic [31:0] v);
    wr(A_SYNC, 8'h01);
    settle(10);
    rd32(A_CNT, v);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 16; a++) begin rd(a, d); chk("R1 reset read", 32'(d), 32'h0); end
    chk("R1 flags low", {30'h0, cmp_flag, ovf_flag}, 32'h0);
  endtask

  task automatic t_load();
    logic [7:0] s; logic [31:0] v;
    wr32(A_CNT, 32'h89AB_CDEF);
    rd(A_STAT, s);
    chk("R8 busy after top byte", 32'(s[0]), 32'h1);
    wait_idle(); rd(A_STAT, s);
    chk("R8 busy clears", 32'(s[0]), 32'h0);
    settle(60); snap(v);
    chk("R1 R8 byte order and load", v, 32'h89AB_CDEF);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    wr32(A_CNT, 32'h1122_3344);
    wr32(A_CNT, 32'h5566_7788);
    wait_idle(); settle(60); snap(v);
    chk("R2 load during busy dropped", v, 32'h1122_3344);
    wr(A_CNT + 3, 8'h99);
    wait_idle(); settle(60); snap(v);
    chk("R2 staging untouched while busy", v, 32'h9922_3344);
  endtask

  task automatic t_snap();
    logic [31:0] v;
    wr32(A_CNT, 32'h0000_00A5);
    wait_idle(); settle(60);
    wr(A_SYNC, 8'h01);
    repeat (7) @(posedge sys_clk);
    @(negedge sys_clk); rd32(A_CNT, v);
    chk("R3 old copy at cycle 7", v, 32'h9922_3344);
    @(posedge sys_clk); @(negedge sys_clk); rd32(A_CNT, v);
    chk("R3 new copy at cycle 8", v, 32'h0000_00A5);
  endtask

  task automatic t_enable();
    logic [31:0] v1, v2;
    settle(100); snap(v1);
    chk("R10 held while disabled", v1, 32'h0000_00A5);
    wr32(A_PER, 32'd1000);
    wr(A_CTRL, 8'h01);
    settle(200); snap(v2);
    chk("R10 advances when enabled", 32'(v2 > v1 && v2 < 32'd1000), 32'h1);
  endtask

  task automatic t_cfg_lock();
    logic [31:0] v; logic [7:0] d;
    wr32(A_PER, 32'd77); rd32(A_PER, v);
    chk("R7 period locked while enabled", v, 32'd1000);
    wr32(A_CMP, 32'd55); rd32(A_CMP, v);
    chk("R7 compare locked while enabled", v, 32'h0);
    wr(A_CTRL, 8'h00); settle(60);
    wr32(A_PER, 32'd77); rd32(A_PER, v);
    chk("R7 period open when stopped", v, 32'd77);
    wr(A_CNT + 3, 8'h00);
    wr(A_PER, 8'h33); rd(A_PER, d);
    chk("R7 period locked while busy", 32'(d), 32'd77);
    wait_idle();
  endtask

  task automatic t_wrap();
    int o0, c0;
    wr32(A_PER, 32'd5); wr32(A_CMP, 32'd0);
    wr32(A_CNT, 32'd1); wait_idle(); settle(40);
    wr(A_FLG, 8'h03);
    o0 = ovf_n; c0 = cmp_n; pair_ok = 0; ovf_last = 0; ovf_gap = 0;
    wr(A_CTRL, 8'h01);
    settle(250);
    wr(A_CTRL, 8'h00); settle(60);
    chk("R4 wrap period is per+1", 32'(ovf_gap), 32'd6);
    chk("R5 overflows seen", 32'(ovf_n - o0 >= 5), 32'h1);
    chk("R5 overflow on step to zero", 32'(pair_ok), 32'(cmp_n - c0));
    chk("R6 compare pulses seen", 32'(cmp_n - c0 >= 5), 32'h1);
    chk("R5 R6 flags set", {30'h0, cmp_flag, ovf_flag}, 32'h3);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    wr(A_FLG, 8'h01); rd(A_FLG, d);
    chk("R11 clear overflow only", 32'(d), 32'h2);
    chk("R11 overflow port low", 32'(ovf_flag), 32'h0);
    wr(A_FLG, 8'h00); rd(A_FLG, d);
    chk("R11 zero write no effect", 32'(d), 32'h2);
    wr(A_FLG, 8'h02); rd(A_FLG, d);
    chk("R11 clear compare", 32'(d), 32'h0);
  endtask

  task automatic t_blank();
    int o0, c0;
    wr32(A_PER, 32'd100); wr32(A_CMP, 32'd100);
    wr32(A_CNT, 32'd0); wait_idle();
    wr(A_CTRL, 8'h01); settle(70);
    o0 = ovf_n; c0 = cmp_n;
    wr32(A_CNT, 32'd100); wait_idle();
    settle(210);
    chk("R9 no overflow after load at period", 32'(ovf_n - o0), 32'h0);
    chk("R9 no compare after load at period", 32'(cmp_n - c0), 32'h0);
    o0 = ovf_n; c0 = cmp_n;
    wr32(A_CNT, 32'd97); wait_idle();
    settle(100);
    chk("R9 control load below period overflows", 32'(ovf_n - o0), 32'h1);
    chk("R9 control load below period compares", 32'(cmp_n - c0), 32'h1);
    wr(A_CTRL, 8'h00); settle(40);
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #95 sys_rst_n = 1'b1; cnt_rst_n = 1'b1;
    @(negedge sys_clk);
    t_reset();
    t_load();
    t_busy();
    t_snap();
    t_enable();
    t_cfg_lock();
    t_wrap();
    t_clear();
    t_blank();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule